// File: doc/BRIEF.md
# Two-Wide Fetch Next-Address Selector

This block decides where instruction fetch goes in the next cycle for a front end that reads two sequential instructions per cycle. The instruction at the fetch address is slot 0, and the one four bytes after it is slot 1. For each slot, the prediction structures report whether the slot holds a known control-flow instruction, what kind it is, a predicted direction and a predicted target. The block takes the first slot in program order that is predicted taken and redirects fetch to that slot's target. If no slot is predicted taken, fetch continues at the sequential address. The block also reports which of the fetched slots are still on the predicted path.

A small circular return-address stack sits inside the block. A call that redirects fetch pushes its link address onto the stack. A return takes its target from the top of the stack and pops it. A resolved target from the back end overrides every prediction in the cycle in which it arrives. In that cycle, no slot of the current fetch group survives and the stack is left untouched.

The next address and the slot mask are combinational outputs for the current cycle. The return stack is the only state the block holds.

Top module: `fetch_npc_sel`

## Requirements
- R1: After reset the return stack is empty and all of its entries are zero, so a return fetched right after reset predicts address 0. While `fetch_valid` is low and no back-end redirect is present, `next_pc` equals `fetch_pc`, `slot_valid` is 2'b00, and the stack does not change.
- R2: A slot is predicted taken when its hit bit is set and either its kind is not conditional or its direction bit is 1. When no slot is predicted taken, `next_pc` is `fetch_pc + 8` and `slot_valid` is 2'b11.
- R3: When slot 0 is predicted taken, `next_pc` is slot 0's target and `slot_valid` is 2'b01. Bit 0 of the mask stands for slot 0 and bit 1 for slot 1. This holds even when slot 1 is also predicted taken.
- R4: When slot 0 is not predicted taken and slot 1 is, `next_pc` is slot 1's target and `slot_valid` is 2'b11.
- R5: Kind encodings are 2'b00 conditional branch, 2'b01 unconditional jump, 2'b10 call and 2'b11 return. Jumps, calls and returns are predicted taken whatever their direction bit says. A slot whose hit bit is clear behaves as an ordinary instruction whatever its kind.
- R6: A redirecting call pushes its own address plus 4: `fetch_pc + 4` from slot 0, or `fetch_pc + 8` from slot 1. A redirecting return predicts the top entry of the stack and pops it, so the stack gives addresses back in last-in first-out order.
- R7: The stack holds 8 entries arranged in a ring. A push onto a full stack overwrites the oldest entry. After 9 pushes, 8 pops return the last 8 pushed addresses, newest first.
- R8: A return fetched while the stack is empty predicts the entry at the current top position and leaves that position unchanged. Two successive returns on an empty stack therefore predict the same address.
- R9: When `be_redirect` is high, `next_pc` is `be_target` and `slot_valid` is 2'b00, whatever the fetch inputs are. No call or return in that cycle touches the stack.
- R10: When slot 1 is nullified because slot 0 redirects, a call or return in slot 1 neither pushes nor pops the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fetch_valid | input | 1 | A fetch group is present this cycle |
| fetch_pc | input | AW | Address of slot 0; slot 1 is at fetch_pc + 4 |
| s0_hit | input | 1 | Slot 0 is a known control-flow instruction |
| s0_kind | input | 2 | Slot 0 kind (see R5) |
| s0_dir | input | 1 | Slot 0 predicted direction (1 = taken) |
| s0_target | input | AW | Slot 0 predicted target |
| s1_hit | input | 1 | Slot 1 is a known control-flow instruction |
| s1_kind | input | 2 | Slot 1 kind (see R5) |
| s1_dir | input | 1 | Slot 1 predicted direction (1 = taken) |
| s1_target | input | AW | Slot 1 predicted target |
| be_redirect | input | 1 | Resolved redirect from the back end |
| be_target | input | AW | Resolved target address |
| next_pc | output | AW | Next fetch address |
| slot_valid | output | 2 | Slots kept on the predicted path (bit 0 = slot 0) |

## Verification
The bench targets several corner cases, each with a distinct failure it would expose:
- Slot 0 and slot 1 both predicted taken. A selector that scans in the wrong order would follow slot 1's target or leave slot 1 valid.
- A call or return sitting in a nullified slot 1. A design that lets that slot act would shift the stack, and a later return would predict the wrong link address.
- Nine calls followed by ten returns. These expose a stack that saturates instead of wrapping, one that returns the oldest entry, and one whose pointer drifts when a return arrives on an empty stack.
- A back-end redirect that coincides with a call or return. A design with the wrong priority would emit the predicted target or let the stack move.

// File: rtl/fnps_pkg.sv
package fnps_pkg;

  // Control-flow kind reported by the prediction structures for a slot.
  typedef enum logic [1:0] {
    CF_COND = 2'b00,
    CF_JUMP = 2'b01,
    CF_CALL = 2'b10,
    CF_RET  = 2'b11
  } cf_kind_e;

  // Bytes per instruction and instructions per fetch group.
  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned FETCH_W    = 2;

endpackage

// File: rtl/fnps_slot_eval.sv
// Per-slot evaluation: is the slot predicted taken, where does it go,
// and what would it do to the return stack.
module fnps_slot_eval
  import fnps_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          hit,
  input  logic [1:0]    kind,
  input  logic          dir,
  input  logic [AW-1:0] pred_tgt,
  input  logic [AW-1:0] stack_top,
  output logic          taken,
  output logic [AW-1:0] dest,
  output logic          is_call,
  output logic          is_ret
);

  cf_kind_e k;

  always_comb begin
    k       = cf_kind_e'(kind);
    is_call = hit && (k == CF_CALL);
    is_ret  = hit && (k == CF_RET);
    unique case (k)
      CF_COND: taken = hit && dir;
      default: taken = hit;
    endcase
    dest = is_ret ? stack_top : pred_tgt;
  end

endmodule

// File: rtl/fnps_ret_stack.sv
// Circular return-address stack. A push onto a full stack overwrites the
// oldest entry; a pop of an empty stack leaves the top position alone.
module fnps_ret_stack #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [AW-1:0]                push_addr,
  output logic [AW-1:0]                top_addr,
  output logic [$clog2(DEPTH)-1:0]     top_ptr,
  output logic [$clog2(DEPTH+1)-1:0]   fill
);

  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] ent_q [DEPTH];
  logic [PW-1:0] ptr_q, ptr_d, ptr_up, ptr_dn;
  logic [CW-1:0] fill_q, fill_d;
  logic          wr_en;

  assign ptr_up = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  assign ptr_dn = (ptr_q == '0) ? LAST : ptr_q - 1'b1;

  // Next-state
  always_comb begin
    ptr_d  = ptr_q;
    fill_d = fill_q;
    wr_en  = 1'b0;
    if (push) begin
      ptr_d  = ptr_up;
      wr_en  = 1'b1;
      fill_d = (fill_q == FULL) ? fill_q : fill_q + 1'b1;
    end else if (pop && (fill_q != '0)) begin
      ptr_d  = ptr_dn;
      fill_d = fill_q - 1'b1;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      fill_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      fill_q <= fill_d;
    end
  end

  // Entry storage, one clock enable per entry
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[e] <= '0;
      end else if (wr_en && (ptr_up == PW'(e))) begin
        ent_q[e] <= push_addr;
      end
    end
  end

  assign top_addr = ent_q[ptr_q];
  assign top_ptr  = ptr_q;
  assign fill     = fill_q;

endmodule

// File: rtl/fnps_select.sv
// Priority selection of the next fetch address across the fetch slots.
module fnps_select
  import fnps_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                 fetch_valid,
  input  logic [AW-1:0]        fetch_pc,
  input  logic [FETCH_W-1:0]   taken,
  input  logic [AW-1:0]        dest [FETCH_W],
  input  logic [FETCH_W-1:0]   is_call,
  input  logic [FETCH_W-1:0]   is_ret,
  input  logic [AW-1:0]        link [FETCH_W],
  input  logic                 be_redirect,
  input  logic [AW-1:0]        be_target,
  output logic [AW-1:0]        next_pc,
  output logic [FETCH_W-1:0]   slot_valid,
  output logic                 stk_push,
  output logic                 stk_pop,
  output logic [AW-1:0]        stk_addr
);

  localparam logic [AW-1:0] GROUP_BYTES = AW'(INSN_BYTES * FETCH_W);

  logic found;

  always_comb begin
    next_pc    = fetch_pc;
    slot_valid = '0;
    stk_push   = 1'b0;
    stk_pop    = 1'b0;
    stk_addr   = '0;
    found      = 1'b0;
    if (be_redirect) begin
      next_pc = be_target;
    end else if (fetch_valid) begin
      next_pc    = fetch_pc + GROUP_BYTES;
      slot_valid = '1;
      for (int s = 0; s < FETCH_W; s++) begin
        if (!found && taken[s]) begin
          found    = 1'b1;
          next_pc  = dest[s];
          stk_push = is_call[s];
          stk_pop  = is_ret[s];
          stk_addr = link[s];
          for (int j = 0; j < FETCH_W; j++) begin
            slot_valid[j] = (j <= s);
          end
        end
      end
    end
  end

endmodule

// File: rtl/fetch_npc_sel.sv
// Two-wide fetch next-address selector with an internal return stack.
// rst_n is asserted asynchronously; its release is synchronised upstream.
module fetch_npc_sel
  import fnps_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic          s0_hit,
  input  logic [1:0]    s0_kind,
  input  logic          s0_dir,
  input  logic [AW-1:0] s0_target,
  input  logic          s1_hit,
  input  logic [1:0]    s1_kind,
  input  logic          s1_dir,
  input  logic [AW-1:0] s1_target,
  input  logic          be_redirect,
  input  logic [AW-1:0] be_target,
  output logic [AW-1:0] next_pc,
  output logic [1:0]    slot_valid
);

  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [FETCH_W-1:0] hit_v, dir_v, taken_v, call_v, ret_v;
  logic [1:0]         kind_v [FETCH_W];
  logic [AW-1:0]      tgt_v  [FETCH_W];
  logic [AW-1:0]      dest_v [FETCH_W];
  logic [AW-1:0]      link_v [FETCH_W];

  logic               stk_push, stk_pop;
  logic [AW-1:0]      stk_addr, stk_top;
  logic [PW-1:0]      stk_ptr;
  logic [CW-1:0]      stk_fill;

  assign hit_v     = {s1_hit, s0_hit};
  assign dir_v     = {s1_dir, s0_dir};
  assign kind_v[0] = s0_kind;
  assign kind_v[1] = s1_kind;
  assign tgt_v[0]  = s0_target;
  assign tgt_v[1]  = s1_target;

  for (genvar s = 0; s < FETCH_W; s++) begin : g_slot
    // Link address is the address of the instruction after this slot.
    assign link_v[s] = fetch_pc + AW'(INSN_BYTES * (s + 1));

    fnps_slot_eval #(.AW(AW)) u_eval (
      .hit       (hit_v[s]),
      .kind      (kind_v[s]),
      .dir       (dir_v[s]),
      .pred_tgt  (tgt_v[s]),
      .stack_top (stk_top),
      .taken     (taken_v[s]),
      .dest      (dest_v[s]),
      .is_call   (call_v[s]),
      .is_ret    (ret_v[s])
    );
  end

  fnps_select #(.AW(AW)) u_sel (
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .taken       (taken_v),
    .dest        (dest_v),
    .is_call     (call_v),
    .is_ret      (ret_v),
    .link        (link_v),
    .be_redirect (be_redirect),
    .be_target   (be_target),
    .next_pc     (next_pc),
    .slot_valid  (slot_valid),
    .stk_push    (stk_push),
    .stk_pop     (stk_pop),
    .stk_addr    (stk_addr)
  );

  fnps_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_ras (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (stk_push),
    .pop       (stk_pop),
    .push_addr (stk_addr),
    .top_addr  (stk_top),
    .top_ptr   (stk_ptr),
    .fill      (stk_fill)
  );

endmodule

// File: rtl/fnps_checker.sv
module fnps_checker
  import fnps_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       fetch_valid,
  input logic [AW-1:0]              fetch_pc,
  input logic                       s0_hit,
  input logic [1:0]                 s0_kind,
  input logic                       s0_dir,
  input logic                       be_redirect,
  input logic [AW-1:0]              be_target,
  input logic [AW-1:0]              next_pc,
  input logic [1:0]                 slot_valid,
  input logic                       stk_push,
  input logic                       stk_pop,
  input logic [$clog2(DEPTH)-1:0]   stk_ptr,
  input logic [$clog2(DEPTH+1)-1:0] stk_fill
);

  localparam int unsigned CW = $clog2(DEPTH + 1);

  a_r9_redirect_wins: assert property (@(posedge clk) disable iff (!rst_n)
    be_redirect |-> (next_pc == be_target) && (slot_valid == 2'b00));

  a_r9_stack_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    be_redirect |=> $stable(stk_fill) && $stable(stk_ptr));

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !be_redirect) |-> (next_pc == fetch_pc) && (slot_valid == 2'b00));

  a_r1_idle_stack: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !be_redirect) |=> $stable(stk_fill) && $stable(stk_ptr));

  a_r3_slot0_nullifies: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !be_redirect && s0_hit && (s0_kind != 2'b00 || s0_dir))
      |-> (slot_valid == 2'b01));

  a_r3_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    slot_valid != 2'b10);

  a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stk_fill <= CW'(DEPTH));

  a_r6_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_push && stk_fill < CW'(DEPTH)) |=> stk_fill == $past(stk_fill) + 1'b1);

  a_r6_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_pop && stk_fill != '0) |=> stk_fill == $past(stk_fill) - 1'b1);

  a_r8_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_pop && stk_fill == '0) |=> $stable(stk_ptr) && (stk_fill == '0));

endmodule

bind fetch_npc_sel fnps_checker #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_valid (fetch_valid),
  .fetch_pc    (fetch_pc),
  .s0_hit      (s0_hit),
  .s0_kind     (s0_kind),
  .s0_dir      (s0_dir),
  .be_redirect (be_redirect),
  .be_target   (be_target),
  .next_pc     (next_pc),
  .slot_valid  (slot_valid),
  .stk_push    (stk_push),
  .stk_pop     (stk_pop),
  .stk_ptr     (stk_ptr),
  .stk_fill    (stk_fill)
);

// File: tb/fetch_npc_sel_bench.sv
`timescale 1ns/1ps
module fetch_npc_sel_bench;

  localparam int AW = 32;
  localparam logic [1:0] K_COND = 2'b00;
  localparam logic [1:0] K_JUMP = 2'b01;
  localparam logic [1:0] K_CALL = 2'b10;
  localparam logic [1:0] K_RET  = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fetch_valid;
  logic [AW-1:0] fetch_pc;
  logic          s0_hit, s0_dir, s1_hit, s1_dir;
  logic [1:0]    s0_kind, s1_kind;
  logic [AW-1:0] s0_target, s1_target;
  logic          be_redirect;
  logic [AW-1:0] be_target;
  logic [AW-1:0] next_pc;
  logic [1:0]    slot_valid;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fetch_npc_sel u_fetch_npc_sel (
    .clk, .rst_n, .fetch_valid, .fetch_pc,
    .s0_hit, .s0_kind, .s0_dir, .s0_target,
    .s1_hit, .s1_kind, .s1_dir, .s1_target,
    .be_redirect, .be_target, .next_pc, .slot_valid
  );

  task automatic chk(string req, logic [AW-1:0] act_pc, logic [AW-1:0] exp_pc,
                     logic [1:0] act_m, logic [1:0] exp_m);
    n_run++;
    if (act_pc !== exp_pc || act_m !== exp_m) begin
      n_fail++;
      $display("FAIL %s: next_pc=%h mask=%b expected next_pc=%h mask=%b",
               req, act_pc, act_m, exp_pc, exp_m);
    end
  endtask

  task automatic idle();
    fetch_valid = 1'b0; fetch_pc = '0;
    s0_hit = 0; s0_kind = K_COND; s0_dir = 0; s0_target = '0;
    s1_hit = 0; s1_kind = K_COND; s1_dir = 0; s1_target = '0;
    be_redirect = 0; be_target = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive one fetch group at the falling edge and let outputs settle.
  task automatic go(logic [AW-1:0] pc,
                    logic h0, logic [1:0] k0, logic d0, logic [AW-1:0] t0,
                    logic h1, logic [1:0] k1, logic d1, logic [AW-1:0] t1);
    @(negedge clk);
    fetch_valid = 1'b1; be_redirect = 1'b0; fetch_pc = pc;
    s0_hit = h0; s0_kind = k0; s0_dir = d0; s0_target = t0;
    s1_hit = h1; s1_kind = k1; s1_dir = d1; s1_target = t1;
    #2;
  endtask

  task automatic ret0(logic [AW-1:0] pc);
    go(pc, 1, K_RET, 0, 32'hDEAD_0000, 0, K_COND, 0, '0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle(); fetch_pc = 32'h100;
    #5; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    fetch_pc = 32'h100;
    #2 chk("R1 idle holds pc", next_pc, 32'h100, slot_valid, 2'b00);
    ret0(32'h200);
    chk("R1 empty return after reset", next_pc, 32'h0, slot_valid, 2'b01);
    ret0(32'h300);
    chk("R8 second empty return same", next_pc, 32'h0, slot_valid, 2'b01);
  endtask

  task automatic t_seq();
    do_reset();
    go(32'h1000, 0, K_JUMP, 1, 32'h5000, 0, K_CALL, 1, 32'h6000);
    chk("R5 no-hit slots sequential", next_pc, 32'h1008, slot_valid, 2'b11);
    go(32'h1010, 1, K_COND, 0, 32'h5000, 1, K_COND, 0, 32'h6000);
    chk("R2 both not taken", next_pc, 32'h1018, slot_valid, 2'b11);
  endtask

  task automatic t_slot0();
    do_reset();
    go(32'h2000, 1, K_COND, 1, 32'h2400, 1, K_JUMP, 0, 32'h3000);
    chk("R3 slot0 taken wins", next_pc, 32'h2400, slot_valid, 2'b01);
    go(32'h2100, 1, K_JUMP, 0, 32'h2800, 0, K_COND, 0, '0);
    chk("R5 jump taken despite dir=0", next_pc, 32'h2800, slot_valid, 2'b01);
  endtask

  task automatic t_slot1();
    do_reset();
    go(32'h4000, 1, K_COND, 0, 32'h4400, 1, K_COND, 1, 32'h4800);
    chk("R4 slot1 taken", next_pc, 32'h4800, slot_valid, 2'b11);
    go(32'h4100, 0, K_JUMP, 1, 32'h4400, 1, K_JUMP, 0, 32'h4C00);
    chk("R4 slot1 jump after no-hit", next_pc, 32'h4C00, slot_valid, 2'b11);
  endtask

  task automatic t_ras();
    do_reset();
    go(32'h500, 1, K_CALL, 0, 32'h800, 0, K_COND, 0, '0);
    chk("R6 slot0 call", next_pc, 32'h800, slot_valid, 2'b01);
    go(32'h900, 0, K_COND, 0, '0, 1, K_CALL, 0, 32'hA00);
    chk("R6 slot1 call", next_pc, 32'hA00, slot_valid, 2'b11);
    ret0(32'hA00);
    chk("R6 return pops slot1 link", next_pc, 32'h908, slot_valid, 2'b01);
    go(32'hB00, 1, K_COND, 0, '0, 1, K_RET, 0, 32'hDEAD);
    chk("R6 slot1 return pops slot0 link", next_pc, 32'h504, slot_valid, 2'b11);
  endtask

  task automatic t_nullify();
    do_reset();
    go(32'h600, 1, K_CALL, 0, 32'h700, 1, K_RET, 0, 32'hDEAD);
    chk("R10 call then nullified return", next_pc, 32'h700, slot_valid, 2'b01);
    go(32'h700, 1, K_JUMP, 0, 32'h780, 1, K_CALL, 0, 32'hBEEF);
    chk("R10 jump then nullified call", next_pc, 32'h780, slot_valid, 2'b01);
    ret0(32'h780);
    chk("R10 stack untouched by slot1", next_pc, 32'h604, slot_valid, 2'b01);
  endtask

  task automatic t_redirect();
    do_reset();
    go(32'h200, 1, K_CALL, 0, 32'h400, 0, K_COND, 0, '0);
    chk("R6 setup call", next_pc, 32'h400, slot_valid, 2'b01);
    go(32'h400, 1, K_RET, 0, '0, 0, K_COND, 0, '0);
    be_redirect = 1'b1; be_target = 32'h9000; #2;
    chk("R9 redirect over return", next_pc, 32'h9000, slot_valid, 2'b00);
    go(32'h9000, 1, K_CALL, 0, 32'hC00, 0, K_COND, 0, '0);
    be_redirect = 1'b1; be_target = 32'h9100; #2;
    chk("R9 redirect over call", next_pc, 32'h9100, slot_valid, 2'b00);
    go(32'h9100, 1, K_CALL, 0, 32'hC00, 0, K_COND, 0, '0);
    fetch_valid = 1'b0; #2;
    chk("R1 idle ignores call", next_pc, 32'h9100, slot_valid, 2'b00);
    ret0(32'h9100);
    chk("R9 stack intact after redirect", next_pc, 32'h204, slot_valid, 2'b01);
  endtask

  task automatic t_wrap();
    do_reset();
    for (int k = 1; k <= 9; k++) begin
      go(32'h1000 * k, 1, K_CALL, 0, 32'h8000, 0, K_COND, 0, '0);
    end
    for (int k = 9; k >= 2; k--) begin
      ret0(32'h8000);
      chk("R7 wrapped pop order", next_pc, 32'h1000 * k + 4, slot_valid, 2'b01);
    end
    ret0(32'h8000);
    chk("R8 empty return after drain", next_pc, 32'h9004, slot_valid, 2'b01);
    ret0(32'h8000);
    chk("R8 repeated empty return", next_pc, 32'h9004, slot_valid, 2'b01);
  endtask

  initial begin
    t_reset();
    t_seq();
    t_slot0();
    t_slot1();
    t_ras();
    t_nullify();
    t_redirect();
    t_wrap();
    @(negedge clk);
    idle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule